// File: doc/BRIEF.md
# Cascadable Serial Configuration Memory Reader

This block is the read side of a small configuration memory that feeds a bitstream to a programmable device. Once power is good, a hold counter keeps the part in reset for a fixed number of clocks. After that, while the chip-select pin is Low and the active-low enable/reset pin is High, an internal position counter walks the on-chip array one step per rising clock. The array word or bit at the current position is presented on the data output.

When the position moves beyond the highest array address, the terminal count, the counter stops and the data output floats. The cascade output then goes Low, so the next memory in a chain can take over at its own address 0. The chain therefore delivers one unbroken stream. Taking chip-select High puts the part in standby, and taking enable/reset Low holds it in reset. In both cases the counter returns to zero. A build option selects whole-word parallel output instead of serial output. The data output is modelled as a value plus a separate drive-enable.

Top module: `cfg_stream_rom`

## Requirements
- R1: While `chip_sel_n` is High (standby), the position counter is held at zero, `data_oe` is Low, `data_out` reads all zeros and `cascade_n` is High, whatever `oe_rst_n` does.
- R2: While `oe_rst_n` is Low, the position counter is held at zero, `data_oe` is Low, `data_out` reads zero and `cascade_n` is High. When the pin returns High, the stream restarts from position 0.
- R3: While running (hold done, `oe_rst_n` High, `chip_sel_n` Low) with the position at or below the terminal count, `data_oe` is High, `cascade_n` is High, and the position advances by one on each rising clock.
- R4: Once the position is one past the terminal count, it no longer changes while running, `data_oe` is Low, `data_out` is zero and `cascade_n` is Low.
- R5: The array word at index i is (i*37 + SEED) mod 2^WORD_W. In serial mode (PARALLEL=0), position p drives `data_out[0]` with bit WORD_W-1-(p mod WORD_W) of word p/WORD_W, so each word goes out MSB first. The terminal count is DEPTH*WORD_W-1.
- R6: While `power_good` is Low, everything is reset asynchronously. For HOLD_CYCLES rising clocks after it rises, the part behaves as if `oe_rst_n` were Low.
- R7: In parallel mode (PARALLEL=1), position p drives word p on `data_out[WORD_W-1:0]`, one word per clock. The terminal count is DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| power_good | input | 1 | Supply valid; Low resets asynchronously |
| oe_rst_n | input | 1 | Output enable, active-low reset of the position |
| chip_sel_n | input | 1 | Chip select, High selects standby |
| data_out | output | OUT_W (1 serial, WORD_W parallel) | Stream data, zero while not driven |
| data_oe | output | 1 | Drive enable for data_out (Low means high impedance) |
| cascade_n | output | 1 | Low enables the next device in the chain |

## Verification
The terminal-count handoff can land in the same cycle as standby or reset. The bench keeps both stream lengths running long enough that chip-select rises and power drops while the position sits at or near the terminal count. In that cycle the expectation has standby or reset winning: `cascade_n` High, drive released, and position 0 on resume rather than a frozen end state. A serial and a parallel instance share every control pin, so each sequence judges both variants cycle by cycle against a position model kept in the bench.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;

   // Array content as a closed formula: no table, no external file.
   function automatic logic [31:0] word_at(input int idx, input int seed);
      return 32'((idx * 37) + seed);
   endfunction

endpackage

// File: rtl/cfgrom_powerup.sv
module cfgrom_powerup #(
   parameter int HOLD_CYCLES = 250000
) (
   input  logic clk,
   input  logic rst_n,
   output logic ready
);
   localparam int CW = $clog2(HOLD_CYCLES + 1);

   logic [CW-1:0] cnt;

   if (HOLD_CYCLES < 1) begin : g_bad_hold
      $error("HOLD_CYCLES must be at least 1");
   end

   assign ready = (cnt == CW'(HOLD_CYCLES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (!ready) cnt <= cnt + 1'b1;
   end

   AST_HOLD_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |=> (cnt == $past(cnt) + 1'b1)); // R6
   AST_HOLD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready); // R6
endmodule

// File: rtl/cfgrom_addr.sv
module cfgrom_addr #(
   parameter int STEPS = 64,
   localparam int PW   = $clog2(STEPS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   output logic [PW-1:0] pos,
   output logic          at_end
);
   if (STEPS < 2) begin : g_bad_steps
      $error("STEPS must be at least 2");
   end

   assign at_end = (pos == PW'(STEPS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pos <= '0;
      else if (!run)    pos <= '0;
      else if (!at_end) pos <= pos + 1'b1;
   end

   AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (pos == '0)); // R2
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !at_end) |=> (pos == $past(pos) + 1'b1)); // R3
   AST_FREEZE_END: assert property (@(posedge clk) disable iff (!rst_n)
      (run && at_end) |=> $stable(pos)); // R4
endmodule

// File: rtl/cfgrom_array.sv
module cfgrom_array #(
   parameter int DEPTH    = 8,
   parameter int WORD_W   = 8,
   parameter bit PARALLEL = 1'b0,
   parameter int SEED     = 90,
   parameter int PW       = 7,
   localparam int OUT_W   = PARALLEL ? WORD_W : 1,
   localparam int LB      = $clog2(WORD_W)
) (
   input  logic [PW-1:0]    pos,
   output logic [OUT_W-1:0] bits
);
   import cfgrom_pkg::*;

   if ((WORD_W < 2) || (WORD_W > 32) || ((1 << LB) != WORD_W)) begin : g_bad_width
      $error("WORD_W must be a power of two from 2 to 32");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end

   logic [31:0]       raw;
   logic [WORD_W-1:0] wrd;

   assign wrd = raw[WORD_W-1:0];

   if (PARALLEL) begin : g_par
      // one whole word per position
      assign raw  = word_at(int'(pos), SEED);
      assign bits = wrd;
   end else begin : g_ser
      // word index from upper position bits, MSB-first bit pick
      logic [LB-1:0] off;
      logic [LB-1:0] sel;
      assign raw  = word_at(int'(pos >> LB), SEED);
      assign off  = pos[LB-1:0];
      assign sel  = LB'(WORD_W - 1) - off;
      assign bits = wrd[sel];
   end
endmodule

// File: rtl/cfg_stream_rom.sv
module cfg_stream_rom #(
   parameter int DEPTH       = 8,
   parameter int WORD_W      = 8,
   parameter bit PARALLEL    = 1'b0,
   parameter int HOLD_CYCLES = 250000,
   parameter int SEED        = 90,
   localparam int OUT_W      = PARALLEL ? WORD_W : 1,
   localparam int STEPS      = PARALLEL ? DEPTH : DEPTH * WORD_W,
   localparam int PW         = $clog2(STEPS + 1)
) (
   input  logic             clk,
   input  logic             power_good,
   input  logic             oe_rst_n,
   input  logic             chip_sel_n,
   output logic [OUT_W-1:0] data_out,
   output logic             data_oe,
   output logic             cascade_n
);
   logic          hold_ready;
   logic          run;
   logic [PW-1:0] pos;
   logic          at_end;
   logic [OUT_W-1:0] arr_bits;

   cfgrom_powerup #(.HOLD_CYCLES(HOLD_CYCLES)) u_pwr (
      .clk   (clk),
      .rst_n (power_good),
      .ready (hold_ready)
   );

   assign run = hold_ready && oe_rst_n && !chip_sel_n;

   cfgrom_addr #(.STEPS(STEPS)) u_addr (
      .clk    (clk),
      .rst_n  (power_good),
      .run    (run),
      .pos    (pos),
      .at_end (at_end)
   );

   cfgrom_array #(
      .DEPTH(DEPTH), .WORD_W(WORD_W), .PARALLEL(PARALLEL), .SEED(SEED), .PW(PW)
   ) u_arr (
      .pos  (pos),
      .bits (arr_bits)
   );

   assign data_oe   = run && !at_end;
   assign cascade_n = !(run && at_end);
   assign data_out  = data_oe ? arr_bits : '0;

   AST_STANDBY_FLOAT: assert property (@(posedge clk) disable iff (!power_good)
      chip_sel_n |-> (!data_oe && cascade_n && data_out == '0)); // R1
   AST_RESET_FLOAT: assert property (@(posedge clk) disable iff (!power_good)
      !oe_rst_n |-> (!data_oe && cascade_n)); // R2
   AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!power_good)
      !(data_oe && !cascade_n)); // R4
   AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!power_good)
      !hold_ready |-> (!data_oe && cascade_n)); // R6
endmodule

// File: tb/sim_cfg_stream_rom.sv
module sim_cfg_stream_rom;
   localparam int DEPTH = 8;
   localparam int WW    = 8;
   localparam int HOLD  = 20;
   localparam int SEED  = 90;
   localparam int NS    = DEPTH * WW;
   localparam int NP    = DEPTH;

   logic clk = 1'b0;
   logic power_good = 1'b1;
   logic oe_rst_n = 1'b0;
   logic chip_sel_n = 1'b1;
   logic [0:0]    s_data;
   logic          s_oe, s_cas;
   logic [WW-1:0] p_data;
   logic          p_oe, p_cas;

   always #2 clk = ~clk;

   cfg_stream_rom #(.DEPTH(DEPTH), .WORD_W(WW), .PARALLEL(1'b0), .HOLD_CYCLES(HOLD), .SEED(SEED)) u0 (
      .clk(clk), .power_good(power_good), .oe_rst_n(oe_rst_n), .chip_sel_n(chip_sel_n),
      .data_out(s_data), .data_oe(s_oe), .cascade_n(s_cas));
   cfg_stream_rom #(.DEPTH(DEPTH), .WORD_W(WW), .PARALLEL(1'b1), .HOLD_CYCLES(HOLD), .SEED(SEED)) u1 (
      .clk(clk), .power_good(power_good), .oe_rst_n(oe_rst_n), .chip_sel_n(chip_sel_n),
      .data_out(p_data), .data_oe(p_oe), .cascade_n(p_cas));

   typedef struct {
      logic          s_oe, s_cas, s_d;
      logic          p_oe, p_cas;
      logic [WW-1:0] p_d;
      string         tag_s, tag_p, dtag_s, dtag_p;
   } exp_t;

   exp_t q[$];
   int tests = 0, fails = 0;
   bit done = 1'b0;

   int hc = 0, ps = 0, pp = 0;
   logic m_pg = 1'b0, m_oe = 1'b0, m_cs = 1'b1;

   function automatic logic [WW-1:0] word(input int i);
      return WW'((i * 37 + SEED) % 256);
   endfunction

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // driver: one clock step, then new inputs and the expected outputs
   task automatic step(input logic pg, input logic oe, input logic cs);
      bit run, act;
      exp_t e;
      @(posedge clk);
      if (m_pg) begin
         run = (hc == HOLD) && m_oe && !m_cs;
         ps = run ? ((ps < NS) ? ps + 1 : ps) : 0;
         pp = run ? ((pp < NP) ? pp + 1 : pp) : 0;
         if (hc < HOLD) hc++;
      end
      #1;
      power_good = pg; oe_rst_n = oe; chip_sel_n = cs;
      m_pg = pg; m_oe = oe; m_cs = cs;
      if (!pg) begin hc = 0; ps = 0; pp = 0; end
      act = pg && (hc == HOLD) && oe && !cs;
      e.s_oe  = act && (ps < NS);
      e.s_cas = !(act && ps == NS);
      e.s_d   = e.s_oe ? word(ps / WW)[WW - 1 - (ps % WW)] : 1'b0;
      e.p_oe  = act && (pp < NP);
      e.p_cas = !(act && pp == NP);
      e.p_d   = e.p_oe ? word(pp) : '0;
      if (!pg || hc < HOLD) begin
         e.tag_s = "R6"; e.tag_p = "R6"; e.dtag_s = "R6"; e.dtag_p = "R6";
      end else if (cs) begin
         e.tag_s = "R1"; e.tag_p = "R1"; e.dtag_s = "R1"; e.dtag_p = "R1";
      end else if (!oe) begin
         e.tag_s = "R2"; e.tag_p = "R2"; e.dtag_s = "R2"; e.dtag_p = "R2";
      end else begin
         e.tag_s  = (ps == NS) ? "R4" : "R3";
         e.tag_p  = (pp == NP) ? "R4" : "R3";
         e.dtag_s = (ps == NS) ? "R4" : "R5";
         e.dtag_p = (pp == NP) ? "R4" : "R7";
      end
      q.push_back(e);
   endtask

   task automatic steps(input int n, input logic pg, input logic oe, input logic cs);
      for (int i = 0; i < n; i++) step(pg, oe, cs);
   endtask

   // monitor: pops one expectation per falling edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         chk(s_oe  == e.s_oe,  e.tag_s,  "serial data_oe",   int'(s_oe),  int'(e.s_oe));
         chk(s_cas == e.s_cas, e.tag_s,  "serial cascade_n", int'(s_cas), int'(e.s_cas));
         chk(s_data[0] == e.s_d, e.dtag_s, "serial data",    int'(s_data[0]), int'(e.s_d));
         chk(p_oe  == e.p_oe,  e.tag_p,  "parallel data_oe", int'(p_oe),  int'(e.p_oe));
         chk(p_cas == e.p_cas, e.tag_p,  "parallel cascade_n", int'(p_cas), int'(e.p_cas));
         chk(p_data == e.p_d,  e.dtag_p, "parallel data",    int'(p_data), int'(e.p_d));
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      #1 power_good = 1'b0;
      steps(3, 1'b0, 1'b1, 1'b0);          // R6: supply low, reset state
      steps(HOLD + 6, 1'b1, 1'b1, 1'b0);   // R6 hold, then R3/R5/R7 stream
      steps(NS, 1'b1, 1'b1, 1'b0);         // serial reaches end, R4 freeze
      steps(3, 1'b1, 1'b0, 1'b0);          // R2 enable low
      steps(3, 1'b1, 1'b0, 1'b1);          // R1 standby regardless of enable
      steps(12, 1'b1, 1'b1, 1'b0);         // R2 restart from position 0
      steps(3, 1'b1, 1'b1, 1'b1);          // R1 standby mid-stream
      steps(NS, 1'b1, 1'b1, 1'b0);         // last serial bit just shown
      steps(1, 1'b1, 1'b1, 1'b1);          // standby at the handoff edge (R1 over R4)
      steps(NS + 2, 1'b1, 1'b1, 1'b0);     // full run, R4 at end
      steps(1, 1'b1, 1'b0, 1'b0);          // R2 at terminal count
      steps(30, 1'b1, 1'b1, 1'b0);
      steps(2, 1'b0, 1'b1, 1'b0);          // R6 power drop mid-stream
      steps(HOLD + 10, 1'b1, 1'b1, 1'b0);  // R6 hold again, then restart
      @(posedge clk);
      @(negedge clk);
      @(negedge clk);
      finish_run();
   end

   initial begin
      #(200000 * 4);
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end
endmodule